// File: doc/BRIEF.md
# Memory-Mapped MDIO Management Bridge

This block sits on a simple 32-bit register bus and turns each bus access into one serial management frame on the MDC/MDIO pair. It takes no command register: the bus address itself carries everything the frame needs. Address bits 11:7 hold the PHY address, bits 6:5 hold a bus opcode, and bits 4:0 hold a five-bit field. For a Clause 22 access that field is the register number. For a Clause 45 access it is the device (MMD) address.

A Clause 45 register is reached in two bus accesses. First, a write with the address opcode carries the 16-bit register number in the low half of the write data. Second, an access with a data opcode transfers the data. There is a second data opcode that asks the PHY to advance its address after a read. The requester holds its request until `bus_ready` pulses. While the frame is on the wire the bus stays stalled. Read data sits in the low 16 bits of `bus_rdata` in the cycle where `bus_ready` is high. The requester must drop `bus_sel` in the cycle after it sees `bus_ready`, or a new access starts.

Top module: `mmio_mdio_bridge`

## Requirements
- R1: Decode: `bus_addr[11:7]` is sent as the 5-bit PHY address and `bus_addr[4:0]` as the 5-bit register/device field. Both go MSB first, right after the 4 start/operation bits.
- R2: Every frame begins with 32 preamble bits, each driven as 1 with `mdio_oe` high. The whole frame is 64 bit times, with 64 rising MDC edges.
- R3: Opcode 1 (`bus_addr[6:5]`=01) produces a Clause 22 frame with start bits 01. The operation bits are 01 for a bus write and 10 for a bus read.
- R4: Opcodes 0, 2 and 3 produce Clause 45 frames with start bits 00. Opcode 0 sends operation 00 and `bus_wdata[15:0]` as the address. Opcode 2 sends 01 on write and 11 on read. Opcode 3 sends 10 on read (read with post-increment) and 01 on write.
- R5: In a write-type frame, MDIO is driven for all 64 bits. The turnaround is driven as 1 then 0, and `bus_wdata[15:0]` follows MSB first.
- R6: In a read frame, `mdio_oe` is low for the two turnaround bits and the 16 data bits. Data bits are sampled at the rising MDC edge, MSB first, and returned as `bus_rdata = {16'h0, data}`.
- R7: MDC is low and `mdio_oe` is low while idle. During a frame, MDC has a period of CLK_DIV clocks and is high for CLK_DIV/2 of them. MDIO changes only while MDC is low.
- R8: `bus_ready` is low while a frame runs and is a one-cycle pulse. Counting the clock edge that accepts the request as edge 1, it is high after edge 64*CLK_DIV+2.
- R9: A bus read with opcode 0 sends no frame. `bus_ready` is high after edge 1 and `bus_rdata` is 0.
- R10: After a write access, `bus_rdata` reads 0 during the `bus_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | PHY, opcode and field address |
| bus_wdata | input | DATA_W | Write data; low 16 bits used |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench aims at the operation-bit choice for each of the four opcodes under both directions. A design that mixed up the two Clause 45 read encodings, or sent a read code on an increment write, would put the wrong four bits after the preamble. It also checks the point where MDIO is released in a read. A design off by one there would either fight the PHY's turnaround or leave the first data bit shifted into the wrong position. The opcode-0 read is a short case with no frame; a design that sent a frame for it would stall the bus for a full frame. The exact ready latency and the MDC high-time count catch a divider that is off by one or a ready pulse that comes early.

// File: rtl/mmio_mdio_bridge_pkg.sv
package mmio_mdio_bridge_pkg;

  typedef enum logic [1:0] {
    OPC_C45_ADR = 2'd0,
    OPC_C22     = 2'd1,
    OPC_C45_DAT = 2'd2,
    OPC_C45_INC = 2'd3
  } bus_opc_e;

  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int PAY_BITS   = FRAME_BITS - PRE_BITS;
  // bit position (frame index) where a read releases the line
  localparam int REL_POS    = PRE_BITS + 14;
  // first sampled data bit of a read
  localparam int DAT_POS    = PRE_BITS + 16;

  // start + operation bits for one access
  function automatic logic [3:0] start_op(bus_opc_e opc, logic wr);
    logic [1:0] st;
    logic [1:0] op;
    st = (opc == OPC_C22) ? 2'b01 : 2'b00;
    case (opc)
      OPC_C22:     op = wr ? 2'b01 : 2'b10;
      OPC_C45_ADR: op = 2'b00;
      OPC_C45_DAT: op = wr ? 2'b01 : 2'b11;
      default:     op = wr ? 2'b01 : 2'b10;
    endcase
    return {st, op};
  endfunction

  function automatic logic [PAY_BITS-1:0] build_payload(bus_opc_e opc, logic wr,
      logic [4:0] phy, logic [4:0] fld, logic [15:0] data);
    return {start_op(opc, wr), phy, fld, 2'b10, data};
  endfunction

  function automatic logic frame_is_read(bus_opc_e opc, logic wr);
    return !wr && (opc != OPC_C45_ADR);
  endfunction

  function automatic logic frame_skipped(bus_opc_e opc, logic wr);
    return !wr && (opc == OPC_C45_ADR);
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic bit_end
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  assign rise_tick = run && (cnt == CNT_RISE);
  assign bit_end   = run && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
      if (cnt == CNT_RISE)      mdc <= 1'b1;
      else if (cnt == CNT_LAST) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mmio_mdio_bridge_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [PAY_BITS-1:0] payload,
  input  logic                rd,
  input  logic                bit_end,
  input  logic                rise_tick,
  input  logic                mdio_i,
  output logic                active,
  output logic                frame_rd,
  output logic [5:0]          bit_idx,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic                done,
  output logic [15:0]         rdata
);
  localparam logic [5:0] IDX_LAST = 6'(FRAME_BITS - 1);
  localparam logic [5:0] IDX_PAY  = 6'(PRE_BITS);
  localparam logic [5:0] IDX_REL  = 6'(REL_POS);
  localparam logic [5:0] IDX_DAT  = 6'(DAT_POS);

  logic [PAY_BITS-1:0] pay_q;
  logic                in_pre;

  assign in_pre = bit_idx < IDX_PAY;

  always_comb begin
    if (!active) begin
      mdio_o  = 1'b1;
      mdio_oe = 1'b0;
    end else if (in_pre) begin
      mdio_o  = 1'b1;
      mdio_oe = 1'b1;
    end else begin
      mdio_o  = pay_q[PAY_BITS-1];
      mdio_oe = !(frame_rd && (bit_idx >= IDX_REL));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      frame_rd <= 1'b0;
      bit_idx  <= '0;
      pay_q    <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        frame_rd <= rd;
        bit_idx  <= '0;
        pay_q    <= payload;
        rdata    <= '0;
      end else if (active) begin
        if (rise_tick && frame_rd && (bit_idx >= IDX_DAT))
          rdata <= {rdata[14:0], mdio_i};
        if (bit_end) begin
          if (bit_idx == IDX_LAST) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
          if (!in_pre) pay_q <= pay_q << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mmio_mdio_bridge.sv
module mmio_mdio_bridge
  import mmio_mdio_bridge_pkg::*;
#(
  parameter int CLK_DIV = 40,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ACK} state_e;

  state_e        state;
  bus_opc_e      opc;
  logic [4:0]    phy_f, reg_f;
  logic          skip, start, rd_pend;
  logic          eng_active, eng_rd, eng_done, rise_tick, bit_end;
  logic [5:0]    bit_idx;
  logic [15:0]   eng_rdata;
  logic [PAY_BITS-1:0] payload;

  assign phy_f   = bus_addr[11:7];
  assign opc     = bus_opc_e'(bus_addr[6:5]);
  assign reg_f   = bus_addr[4:0];
  assign skip    = frame_skipped(opc, bus_wr);
  assign payload = build_payload(opc, bus_wr, phy_f, reg_f, bus_wdata[15:0]);
  assign start   = (state == S_IDLE) && bus_sel && !skip;
  assign bus_ready = (state == S_ACK);

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .run(eng_active),
    .mdc(mdc), .rise_tick(rise_tick), .bit_end(bit_end)
  );

  mdio_frame_engine engine_i (
    .clk(clk), .rst_n(rst_n), .start(start), .payload(payload),
    .rd(frame_is_read(opc, bus_wr)), .bit_end(bit_end), .rise_tick(rise_tick),
    .mdio_i(mdio_i), .active(eng_active), .frame_rd(eng_rd), .bit_idx(bit_idx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(eng_done), .rdata(eng_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rd_pend   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (bus_sel) begin
          if (skip) begin
            state     <= S_ACK;
            bus_rdata <= '0;
          end else begin
            state   <= S_RUN;
            rd_pend <= frame_is_read(opc, bus_wr);
          end
        end
        S_RUN: if (eng_done) begin
          state     <= S_ACK;
          bus_rdata <= rd_pend ? DATA_W'(eng_rdata) : '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmio_mdio_bridge_chk.sv
module mmio_mdio_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_ready,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       active,
  input logic       frame_rd,
  input logic [5:0] bit_idx
);
  a_r7_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdc);
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdio_oe);
  a_r7_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mdc && $past(mdc)) |-> $stable(mdio_o));
  a_r2_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_idx < 6'd32) |-> (mdio_oe && mdio_o));
  a_r6_line_released: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frame_rd && bit_idx >= 6'd46) |-> !mdio_oe);
  a_r5_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frame_rd) |-> mdio_oe);
  a_r8_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !active);
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
endmodule

bind mmio_mdio_bridge mmio_mdio_bridge_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .active(eng_active),
  .frame_rd(eng_rd), .bit_idx(bit_idx)
);

// File: tb/mmio_mdio_bridge_tb_top.sv
`timescale 1ns/1ps
module mmio_mdio_bridge_tb_top;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, mdc, mdio_o, mdio_oe, mdio_line;
  logic        phy_drv = 1'b1;

  int checks = 0;
  int fails = 0;
  int mcount = 0;
  logic [63:0] obs_o, obs_oe;
  logic [15:0] resp_data = '0;

  always #2 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : phy_drv;

  mmio_mdio_bridge #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .mdc(mdc), .mdio_i(mdio_line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // observer: one record per rising MDC edge
  always @(posedge mdc) begin
    if (mcount < 64) begin
      obs_o[63 - mcount]  = mdio_o;
      obs_oe[63 - mcount] = mdio_oe;
    end
    mcount = mcount + 1;
  end

  // PHY responder: drives the next bit on the falling MDC edge
  always @(negedge mdc) begin
    if (mcount == 47)                       phy_drv = 1'b0;
    else if (mcount >= 48 && mcount <= 63)  phy_drv = resp_data[63 - mcount];
    else                                    phy_drv = 1'b1;
  end

  function automatic logic [63:0] want_frame(bit wr, logic [11:0] a, logic [31:0] wd);
    logic [3:0] so;
    if (a[6:5] == 2'd1)      so = wr ? 4'b0101 : 4'b0110;
    else if (a[6:5] == 2'd0) so = 4'b0000;
    else if (wr)             so = 4'b0001;
    else                     so = (a[6:5] == 2'd2) ? 4'b0011 : 4'b0010;
    return {32'hFFFF_FFFF, so, a[11:7], a[4:0], 2'b10, wd[15:0]};
  endfunction

  function automatic logic [63:0] want_oe(bit is_rd);
    return is_rd ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(bit wr, logic [11:0] a, logic [31:0] wd, logic [15:0] resp);
    int lat = 0;
    int hi = 0;
    bit skipped = !wr && (a[6:5] == 2'd0);
    bit is_rd = !wr && !skipped;
    logic [63:0] mask = want_oe(is_rd);
    logic [63:0] wf = want_frame(wr, a, wd);
    logic [31:0] got;
    resp_data = resp;
    mcount = 0;
    obs_o = '0;
    obs_oe = '0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (mdc) hi++;
      if (bus_ready || lat > 100000) break;
    end
    got = bus_rdata;
    bus_sel = 1'b0;
    if (skipped) begin
      chk(lat == 1, "R9 latency", lat, 1);
      chk(got == 0, "R9 rdata", got, 0);
      chk(mcount == 0, "R9 no frame", mcount, 0);
    end else begin
      chk(lat == 64*DIV + 2, "R8 ready latency", lat, 64*DIV + 2);
      chk(mcount == 64 && hi == 64*(DIV/2), "R7 mdc edges/high time",
          {mcount[31:0], hi[31:0]}, {32'd64, 32'(64*(DIV/2))});
      chk(obs_o[63:32] == 32'hFFFF_FFFF && obs_oe[63:32] == 32'hFFFF_FFFF,
          "R2 preamble", {obs_o[63:32], obs_oe[63:32]}, 64'hFFFF_FFFF_FFFF_FFFF);
      chk((obs_o[31:18] & 14'h3FFF) == wf[31:18], "R1/R3/R4 header bits",
          obs_o[31:18], wf[31:18]);
      chk(obs_oe == mask, is_rd ? "R6 release pattern" : "R5 drive pattern",
          obs_oe, mask);
      if (is_rd)
        chk(got == {16'h0, resp}, "R6 read data", got, {16'h0, resp});
      else begin
        chk(obs_o[17:0] == wf[17:0], "R5 turnaround+data", obs_o[17:0], wf[17:0]);
        chk(got == 0, "R10 rdata after write", got, 0);
      end
    end
    @(negedge clk);
    chk(!bus_ready, "R8 ready one cycle", bus_ready, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bus_ready && !mdc && !mdio_oe, "R7 reset/idle state",
        {bus_ready, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mdc && !mdio_oe, "R7 idle after reset", {mdc, mdio_oe}, 0);
    // directed: each opcode, both directions, extreme fields
    txn(1'b1, {5'd31, 2'd1, 5'd31}, 32'hDEAD_A5C3, 16'h0);     // R3 write
    txn(1'b0, {5'd0,  2'd1, 5'd0},  32'h0,         16'h8001);  // R3 read
    txn(1'b1, {5'd9,  2'd0, 5'd30}, 32'h0000_FFFF, 16'h0);     // R4 address
    txn(1'b0, {5'd9,  2'd0, 5'd30}, 32'h0,         16'h1234);  // R9 skip
    txn(1'b0, {5'd9,  2'd2, 5'd30}, 32'h0,         16'hFFFF);  // R4 read
    txn(1'b1, {5'd9,  2'd2, 5'd30}, 32'h0000_0000, 16'h0);     // R4 write
    txn(1'b0, {5'd21, 2'd3, 5'd1},  32'h0,         16'h0000);  // R4 read-inc
    txn(1'b1, {5'd21, 2'd3, 5'd1},  32'h0000_5AA5, 16'h0);     // R4 inc write
    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] d = $urandom;
      txn(r[12], r[11:0], d, d[31:16]);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule